// File: doc/BRIEF.md
# Background Memory Scrubber

This block walks a protected memory in the background with no software involvement. Each stored word holds several bytes, and each byte is kept as a 13-bit single-error-correct, double-error-detect codeword. At each address the engine reads the raw word, decodes every byte codeword, and writes a repaired word back only when at least one byte carried a single flipped bit. Bytes with two flipped bits are reported and left as they are. The engine walks a programmable address window in ascending order and wraps around, signalling each completed pass.

The engine shares a single-port memory with a CPU. The CPU always wins the port, and a scrub access that loses simply waits for the next free cycle. An idle-interval setting controls how many clocks the engine rests between visits. Software can change it while the walk runs, to scrub faster when upset rates rise. Two saturating counters and a last-error address register record what the walk found.

Top module: `bg_scrubber`

## Requirements
- R1: After enable, scrub reads visit `cfg_start_addr`, then each following address in ascending order. After the visit to an address at or above `cfg_end_addr` completes, the walk returns to `cfg_start_addr`, and `pass_done` is high for exactly that one cycle.
- R2: Each byte b of a word occupies bits [13b+12:13b]. Inside a byte codeword, bit 0 is the even parity over bits 12..1. Bits 1, 2, 4 and 8 are Hamming checks, each covering the positions that have that bit set in their index. Data bits 0..7 sit at positions 3, 5, 6, 7, 9, 10, 11 and 12. A byte with one flipped bit is rewritten in memory in its correct encoding.
- R3: A scrub write occurs only when the word read contained at least one correctable byte. A clean word, or a word whose only faults are uncorrectable, is never written.
- R4: A byte with overall parity even and a nonzero syndrome, or with parity odd and a syndrome above 12, is uncorrectable. It stays unchanged in memory. `uncorr_cnt` increments once per word visited that holds such a byte, and `last_err_addr` takes that word's address.
- R5: `corr_cnt` increments once per word visited that holds at least one correctable byte. Both counters saturate.
- R6: With the port free, consecutive scrub reads of words that need no write are `cfg_interval`+2 cycles apart.
- R7: A new `cfg_interval` written while the engine runs takes effect at once. The walk continues from its current address.
- R8: A CPU request owns the memory port in the cycle it is raised, and `cpu_rdata` returns the word one cycle later. A blocked scrub access is retried at the same address on the next free cycle.
- R9: A CPU write to the address whose repair is pending cancels the scrub write, so the CPU data survives.
- R10: Clearing `cfg_enable` lets an ongoing read-modify-write finish its write. The engine then issues no further accesses. Setting `cfg_enable` again restarts the walk at `cfg_start_addr`.
- R11: After reset the port is idle, both counters and `last_err_addr` are zero, and `pass_done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Run the background walk |
| cfg_interval | input | IW | Idle clocks between visits |
| cfg_start_addr | input | AW | First address of the window |
| cfg_end_addr | input | AW | Last address of the window |
| cpu_req | input | 1 | CPU access request (wins the port) |
| cpu_we | input | 1 | CPU write when high |
| cpu_addr | input | AW | CPU address |
| cpu_wdata | input | 13*NB | CPU raw codeword data |
| cpu_rdata | output | 13*NB | Raw word read, one cycle after a CPU read |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | 13*NB | Memory write data |
| mem_rdata | input | 13*NB | Memory read data, one cycle latency |
| corr_cnt | output | CNTW | Words found with correctable bytes |
| uncorr_cnt | output | CNTW | Words found with uncorrectable bytes |
| last_err_addr | output | AW | Address of the latest uncorrectable word |
| pass_done | output | 1 | One-cycle pulse on each wrap of the walk |

## Verification
The bench seeds single flips in every bit position class, including the overall parity bit and the top data bit. It also seeds double flips, alone and mixed with singles. A decoder that mislocated a syndrome would then corrupt good bits, and an engine that wrote on uncorrectable-only words would show spurious writes. The bench retunes the interval in mid-walk and measures read spacing. A design that restarted the walk or latched the old interval would then break either the address order or the spacing. Random CPU traffic and long port hogs check that blocked visits skip no address. A CPU write aimed at the word under repair checks that a stale repair cannot overwrite fresh data. Disabling in mid repair checks that the pending write completes and nothing follows it.

// File: rtl/bg_scrubber.sv
module bg_scrubber #(
  parameter int NB   = 4,
  parameter int AW   = 8,
  parameter int IW   = 8,
  parameter int CNTW = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_enable,
  input  logic [IW-1:0]      cfg_interval,
  input  logic [AW-1:0]      cfg_start_addr,
  input  logic [AW-1:0]      cfg_end_addr,
  input  logic               cpu_req,
  input  logic               cpu_we,
  input  logic [AW-1:0]      cpu_addr,
  input  logic [13*NB-1:0]   cpu_wdata,
  output logic [13*NB-1:0]   cpu_rdata,
  output logic               mem_en,
  output logic               mem_we,
  output logic [AW-1:0]      mem_addr,
  output logic [13*NB-1:0]   mem_wdata,
  input  logic [13*NB-1:0]   mem_rdata,
  output logic [CNTW-1:0]    corr_cnt,
  output logic [CNTW-1:0]    uncorr_cnt,
  output logic [AW-1:0]      last_err_addr,
  output logic               pass_done
);
  localparam int CW = 13 * NB;

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_RD, S_CHK, S_WR} st_t;

  function automatic logic [12:0] enc13(input logic [7:0] d);
    logic [12:0] c;
    c = '0;
    c[3] = d[0]; c[5] = d[1]; c[6] = d[2]; c[7] = d[3];
    c[9] = d[4]; c[10] = d[5]; c[11] = d[6]; c[12] = d[7];
    c[1] = c[3] ^ c[5] ^ c[7] ^ c[9] ^ c[11];
    c[2] = c[3] ^ c[6] ^ c[7] ^ c[10] ^ c[11];
    c[4] = c[5] ^ c[6] ^ c[7] ^ c[12];
    c[8] = c[9] ^ c[10] ^ c[11] ^ c[12];
    c[0] = ^c[12:1];
    return c;
  endfunction

  function automatic logic [9:0] dec13(input logic [12:0] c);
    logic [3:0]  syn;
    logic [12:0] f;
    logic        sgl, dbl;
    syn = '0;
    for (int i = 1; i < 13; i++)
      if (c[i]) syn = syn ^ 4'(i);
    f   = c;
    sgl = 1'b0;
    dbl = 1'b0;
    if (^c) begin
      if (syn == 4'd0) f[0] = ~f[0];
      else if (syn > 4'd12) dbl = 1'b1;
      else
        for (int i = 1; i < 13; i++)
          if (syn == 4'(i)) f[i] = ~f[i];
      sgl = ~dbl;
    end else if (syn != 4'd0) begin
      dbl = 1'b1;
    end
    return {sgl, dbl, f[12], f[11], f[10], f[9], f[7], f[6], f[5], f[3]};
  endfunction

  st_t           st;
  logic [AW-1:0] addr;
  logic [IW-1:0] gap;
  logic [CW-1:0] fix_q;

  logic [NB-1:0] rd_single, rd_double;
  logic [CW-1:0] fix_word;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    logic [9:0] dres;
    assign dres         = dec13(mem_rdata[b*13 +: 13]);
    assign rd_single[b] = dres[9];
    assign rd_double[b] = dres[8];
    assign fix_word[b*13 +: 13] = dres[8] ? mem_rdata[b*13 +: 13] : enc13(dres[7:0]);
  end

  logic any_fix, any_bad, cpu_hit, scrub_rd, scrub_wr;
  logic chk_end, wr_cancel, visit_end, at_end, gap_done;
  logic [AW-1:0] next_addr;

  assign any_fix   = |rd_single;
  assign any_bad   = |rd_double;
  assign cpu_hit   = cpu_req && cpu_we && (cpu_addr == addr);
  assign scrub_rd  = (st == S_RD) && cfg_enable && !cpu_req;
  assign scrub_wr  = (st == S_WR) && !cpu_req;
  assign chk_end   = (st == S_CHK) && (!any_fix || cpu_hit);
  assign wr_cancel = (st == S_WR) && cpu_hit;
  assign visit_end = chk_end || scrub_wr || wr_cancel;
  assign at_end    = addr >= cfg_end_addr;
  assign next_addr = at_end ? cfg_start_addr : AW'(addr + AW'(1));
  assign gap_done  = ((IW+1)'(gap) + (IW+1)'(1)) >= (IW+1)'(cfg_interval);
  assign pass_done = visit_end && at_end;

  assign mem_en    = cpu_req || scrub_rd || scrub_wr;
  assign mem_we    = cpu_req ? cpu_we : scrub_wr;
  assign mem_addr  = cpu_req ? cpu_addr : addr;
  assign mem_wdata = cpu_req ? cpu_wdata : fix_q;
  assign cpu_rdata = mem_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      addr  <= '0;
      gap   <= '0;
      fix_q <= '0;
    end else begin
      unique case (st)
        S_IDLE: begin
          addr <= cfg_start_addr;
          if (cfg_enable) st <= S_RD;
        end
        S_WAIT: begin
          if (!cfg_enable) st <= S_IDLE;
          else if (gap_done) st <= S_RD;
          else gap <= gap + IW'(1);
        end
        S_RD: begin
          if (!cfg_enable) st <= S_IDLE;
          else if (!cpu_req) st <= S_CHK;
        end
        S_CHK: begin
          if (any_fix && !cpu_hit) begin
            fix_q <= fix_word;
            st    <= S_WR;
          end
        end
        S_WR: ;
        default: st <= S_IDLE;
      endcase
      if (visit_end) begin
        addr <= next_addr;
        gap  <= '0;
        if (!cfg_enable) st <= S_IDLE;
        else if (cfg_interval == '0) st <= S_RD;
        else st <= S_WAIT;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      corr_cnt      <= '0;
      uncorr_cnt    <= '0;
      last_err_addr <= '0;
    end else if (st == S_CHK) begin
      if (any_fix && corr_cnt != '1) corr_cnt <= corr_cnt + CNTW'(1);
      if (any_bad) begin
        last_err_addr <= addr;
        if (uncorr_cnt != '1) uncorr_cnt <= uncorr_cnt + CNTW'(1);
      end
    end
  end

  a_r8_retry_same_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RD && cfg_enable && cpu_req) |=> (st == S_RD || st == S_IDLE) && $stable(addr));

  a_r3_clean_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CHK && !any_fix) |=> st != S_WR);

  a_r9_hit_cancels: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CHK && cpu_hit) |=> st != S_WR);

  a_r1_sequential: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && $past(st) != S_IDLE && addr != $past(addr))
      |-> (addr == AW'($past(addr) + AW'(1)) || addr == cfg_start_addr));

  a_r4_cnt_on_check: assert property (@(posedge clk) disable iff (!rst_n)
    (uncorr_cnt != $past(uncorr_cnt)) |-> $past(st) == S_CHK);

  a_r10_finish_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WR && !cfg_enable && !cpu_req) |=> st == S_IDLE);

  a_r1_pass_single: assert property (@(posedge clk) disable iff (!rst_n)
    pass_done |=> !pass_done);
endmodule

// File: tb/test_bg_scrubber.sv
module test_bg_scrubber;
  localparam int NB = 4, AW = 8, IW = 8, CNTW = 16, CW = 13 * NB;
  localparam logic [AW-1:0] START = 8'd16, STOP = 8'd47;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_enable = 1'b0;
  logic [IW-1:0] cfg_interval = '0;
  logic [AW-1:0] cfg_start_addr = START, cfg_end_addr = STOP;
  logic cpu_req = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [CW-1:0] cpu_wdata = '0, cpu_rdata, mem_wdata, rdata_q = '0;
  logic mem_en, mem_we, pass_done;
  logic [AW-1:0] mem_addr, last_err_addr;
  logic [CNTW-1:0] corr_cnt, uncorr_cnt;

  always #4 clk = ~clk;

  bg_scrubber #(.NB(NB), .AW(AW), .IW(IW), .CNTW(CNTW)) i_bg_scrubber (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_interval(cfg_interval),
    .cfg_start_addr(cfg_start_addr), .cfg_end_addr(cfg_end_addr),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(rdata_q), .corr_cnt(corr_cnt),
    .uncorr_cnt(uncorr_cnt), .last_err_addr(last_err_addr), .pass_done(pass_done));

  logic [CW-1:0] mem [256];
  logic [CW-1:0] exp_mem [256];
  bit unc [256];
  int tests = 0, fails = 0;
  int cyc = 0, sc_rd = 0, sc_wr = 0, pass_cnt = 0, order_err = 0, port_err = 0;
  int last_rd_cyc = 0, last_gap = 0;
  logic [AW-1:0] prev_rd = '0, last_rd_addr = '0;
  bit prev_valid = 0;

  always @(posedge clk) begin
    cyc++;
    if (mem_en) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      rdata_q <= mem[mem_addr];
    end
    if (mem_en && !cpu_req) begin
      if (mem_we) sc_wr++;
      else begin
        sc_rd++;
        if (prev_valid && mem_addr != ((prev_rd == STOP) ? START : prev_rd + 8'd1)) order_err++;
        prev_rd = mem_addr; prev_valid = 1; last_rd_addr = mem_addr;
        last_gap = cyc - last_rd_cyc; last_rd_cyc = cyc;
      end
    end
    if (pass_done) pass_cnt++;
  end

  function automatic logic [12:0] ref_enc(input logic [7:0] d);
    logic [12:0] c;
    int k;
    c = '0; k = 0;
    for (int p = 1; p < 13; p++)
      if ((p & (p - 1)) != 0) begin c[p] = d[k]; k++; end
    for (int q = 0; q < 4; q++) begin
      bit x;
      x = 0;
      for (int p = 1; p < 13; p++)
        if (((p >> q) & 1) == 1 && (p & (p - 1)) != 0) x = x ^ c[p];
      c[1 << q] = x;
    end
    c[0] = ^c[12:1];
    return c;
  endfunction

  function automatic logic [CW-1:0] ref_word(input logic [31:0] d);
    logic [CW-1:0] w;
    for (int b = 0; b < NB; b++) w[b*13 +: 13] = ref_enc(d[b*8 +: 8]);
    return w;
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint expv);
    tests++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic wait_read(input logic [AW-1:0] a);
    do @(negedge clk); while (!(mem_en && !mem_we && !cpu_req && mem_addr == a));
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int n_wr, n_unc, last_unc, bad, r0, w0, p0;
    logic [AW-1:0] x_adr, y_adr;
    logic [CW-1:0] wnew;
    void'($urandom(32'd4242));
    n_wr = 0; n_unc = 0; last_unc = 0;
    for (int a = 0; a < 256; a++) begin
      mem[a] = ref_word($urandom); exp_mem[a] = mem[a]; unc[a] = 0;
    end
    for (int a = START; a <= STOP; a++) begin
      int kind, b, i, j;
      bit wr;
      kind = $urandom % 4; wr = 0;
      if (a == 16 || a == 33) kind = 4;
      if (a == 20 || a == 21 || a == 47) kind = 1;
      b = $urandom % NB;
      if (kind == 1 || kind == 2) begin
        i = (a == 20) ? 0 : (a == 21) ? 12 : $urandom % 13;
        mem[a][b*13 + i] = ~mem[a][b*13 + i]; wr = 1;
      end
      if (kind == 2 || kind == 4) begin
        int bb;
        bb = (kind == 2) ? (b + 1) % NB : b;
        i = $urandom % 13; j = (i + 1 + $urandom % 12) % 13;
        mem[a][bb*13 + i] = ~mem[a][bb*13 + i];
        mem[a][bb*13 + j] = ~mem[a][bb*13 + j];
        exp_mem[a][bb*13 +: 13] = mem[a][bb*13 +: 13];
        unc[a] = 1; n_unc++; last_unc = a;
      end
      if (wr) n_wr++;
    end

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", "reset mem_en", mem_en, 0);
    chk("R11", "reset counters", {corr_cnt, uncorr_cnt}, 0);
    chk("R11", "reset last_err/pass", {last_err_addr, pass_done}, 0);

    cfg_enable = 1'b1;
    while (pass_cnt < 1) @(negedge clk);
    bad = 0;
    for (int a = 0; a < 256; a++) if (mem[a] !== exp_mem[a]) bad++;
    chk("R2", "words differing from expected after pass", bad, 0);
    chk("R3", "scrub writes in first pass", sc_wr, n_wr);
    chk("R5", "corr_cnt", corr_cnt, n_wr);
    chk("R4", "uncorr_cnt", uncorr_cnt, n_unc);
    chk("R4", "last_err_addr", last_err_addr, last_unc);
    chk("R1", "order errors", order_err, 0);
    w0 = sc_wr;
    while (pass_cnt < 2) @(negedge clk);
    chk("R3", "writes in clean second pass", sc_wr, w0);
    chk("R4", "uncorr_cnt after two passes", uncorr_cnt, 2 * n_unc);
    chk("R1", "pass pulses", pass_cnt, 2);

    cfg_interval = 8'd5;
    r0 = sc_rd; while (sc_rd < r0 + 3) @(negedge clk);
    chk("R6", "spacing interval 5", last_gap, 7);
    cfg_interval = 8'd2;
    r0 = sc_rd; while (sc_rd < r0 + 3) @(negedge clk);
    chk("R7", "spacing after live change to 2", last_gap, 4);
    chk("R7", "walk continued without restart", order_err, 0);
    cfg_interval = 8'd0;
    r0 = sc_rd; while (sc_rd < r0 + 3) @(negedge clk);
    chk("R6", "spacing interval 0", last_gap, 2);

    for (int k = 0; k < 8; k++) begin
      int a;
      a = START + $urandom % 32;
      if (!unc[a]) mem[a][($urandom % NB)*13 + $urandom % 13] ^= 1'b1;
    end
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      cpu_req = ($urandom % 2) == 1; cpu_we = ($urandom % 2) == 1;
      cpu_addr = AW'(100 + $urandom % 100); cpu_wdata = ref_word($urandom);
      if (cpu_req && cpu_we) exp_mem[cpu_addr] = cpu_wdata;
      #1;
      if (cpu_req && (mem_addr != cpu_addr || mem_we != cpu_we || !mem_en)) port_err++;
    end
    @(negedge clk); cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 8'd120;
    @(negedge clk); cpu_req = 1'b0;
    chk("R8", "cpu read data", (cpu_rdata == exp_mem[120]), 1);
    chk("R8", "port owned by cpu", port_err, 0);
    @(negedge clk); cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 8'd200;
    r0 = sc_rd;
    repeat (30) @(negedge clk);
    chk("R8", "scrub reads while port hogged", sc_rd, r0);
    cpu_req = 1'b0;
    p0 = pass_cnt; while (pass_cnt < p0 + 2) @(negedge clk);
    bad = 0;
    for (int a = 0; a < 256; a++) if (mem[a] !== exp_mem[a]) bad++;
    chk("R8", "memory after cpu traffic", bad, 0);
    chk("R8", "no skipped address", order_err, 0);

    cfg_interval = 8'd3;
    x_adr = 8'd30; while (unc[x_adr]) x_adr++;
    mem[x_adr][5] ^= 1'b1;
    wait_read(x_adr);
    w0 = sc_wr;
    @(negedge clk);
    wnew = ref_word($urandom);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = x_adr; cpu_wdata = wnew;
    exp_mem[x_adr] = wnew;
    @(negedge clk); cpu_req = 1'b0;
    repeat (10) @(negedge clk);
    chk("R9", "scrub writes after colliding cpu write", sc_wr, w0);
    chk("R9", "cpu data kept", (mem[x_adr] == wnew), 1);

    y_adr = 8'd40; while (unc[y_adr]) y_adr++;
    mem[y_adr][13 + 7] ^= 1'b1;
    wait_read(y_adr);
    @(negedge clk); cfg_enable = 1'b0;
    repeat (6) @(negedge clk);
    chk("R10", "repair finished after disable", (mem[y_adr] == exp_mem[y_adr]), 1);
    r0 = sc_rd + sc_wr;
    repeat (20) @(negedge clk);
    chk("R10", "no access while disabled", sc_rd + sc_wr + int'(mem_en), r0);
    prev_valid = 0;
    cfg_enable = 1'b1;
    r0 = sc_rd; while (sc_rd < r0 + 1) @(negedge clk);
    chk("R10", "restart address", last_rd_addr, START);
    p0 = pass_cnt; while (pass_cnt < p0 + 1) @(negedge clk);
    bad = 0;
    for (int a = 0; a < 256; a++) if (mem[a] !== exp_mem[a]) bad++;
    chk("R2", "final memory image", bad, 0);
    chk("R1", "final order errors", order_err, 0);
    summary();
    $finish;
  end
endmodule